// File: doc/BRIEF.md
# Reset, Watchdog and Wake Controller

This block decides when the processor core restarts, and from where. It counts ticks of a slow enable on a watchdog. It keeps two status flags, a time-out flag and a power-down flag. Firmware reads these flags after a restart to learn what caused it. The block also holds the core's clock stopped while the core sleeps.

Five events can restart or wake the core:
- power-on reset;
- a watchdog overflow while awake;
- a watchdog overflow while asleep;
- an interrupt while asleep;
- a USB bus reset.

Each event leaves its own combination of flag values and restart address. A reset sends the core to the reset vector (address 0). A wake lets the core continue at the instruction after the sleep (PC+1). The core signals two instructions to the block with single-cycle strobes: clear-watchdog and sleep.

All outputs are registered in the `clk_i` domain. Reset and wake appear as one-cycle pulses. A pulse comes together with the updated flags and the PC-select level.

Top module: `rst_wake_ctrl`

## Requirements
- R1: While `rst_ni` is low, `core_rst_o`=1, `to_flag_o`=1, `pd_flag_o`=1, `wake_o`=0, `clk_stop_o`=0, `pc_inc_o`=0. `core_rst_o` drops at the first clock edge after release, and the watchdog count starts at zero.
- R2: While awake, the watchdog overflows on the `WDT_TICKS`-th `tick_i` cycle counted since it was last zeroed. On that edge the block gives:
  - a one-cycle `core_rst_o` pulse;
  - `to_flag_o`=0 and `pd_flag_o`=1;
  - `pc_inc_o`=0 (restart at the reset vector).
- R3: A `wdt_clr_i` strobe while awake zeroes the watchdog count and sets both flags to 1.
- R4: A `sleep_i` strobe while awake zeroes the watchdog count, sets `clk_stop_o`=1, and sets `to_flag_o`=1 and `pd_flag_o`=0.
- R5: A watchdog overflow while asleep gives:
  - a one-cycle `wake_o` pulse;
  - `to_flag_o`=0 and `pd_flag_o`=0;
  - `pc_inc_o`=1 (continue at PC+1);
  - `clk_stop_o`=0.
- R6: `irq_pend_i`=1 while asleep gives:
  - a one-cycle `wake_o` pulse;
  - `to_flag_o`=1 and `pd_flag_o`=0;
  - `pc_inc_o`=1;
  - `clk_stop_o`=0.
- R7: A rising edge of `usb_rst_i`, asleep or awake, gives a single `core_rst_o` pulse with `pc_inc_o`=0. It also clears `clk_stop_o` and zeroes the watchdog count, and it leaves both flags unchanged. Holding `usb_rst_i` high gives no further pulses.
- R8: While asleep, `wdt_clr_i` and `sleep_i` are ignored: the flags keep their values and the watchdog count is not zeroed.
- R9: When events coincide, a USB reset edge beats a watchdog overflow, and a watchdog overflow beats an interrupt wake.
- R10: `wake_o` and `core_rst_o` are never high together, and `wake_o` never lasts more than one cycle.
- R11: `irq_pend_i` has no effect while awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| tick_i | input | 1 | Slow watchdog enable, one cycle per tick |
| usb_rst_i | input | 1 | USB bus reset level |
| wdt_clr_i | input | 1 | Clear-watchdog instruction strobe |
| sleep_i | input | 1 | Sleep instruction strobe |
| irq_pend_i | input | 1 | Interrupt pending |
| core_rst_o | output | 1 | Core restart pulse (reset vector) |
| wake_o | output | 1 | Wake pulse (continue at PC+1) |
| pc_inc_o | output | 1 | Restart address select: 0 reset vector, 1 PC+1 |
| to_flag_o | output | 1 | Time-out status flag |
| pd_flag_o | output | 1 | Power-down status flag |
| clk_stop_o | output | 1 | Request to stop the core clock while asleep |

## Verification
The bench builds the block with `WDT_TICKS` = 4. With that setting, a full watchdog period takes only a few directed tick cycles. The bench can then test each overflow boundary directly: no restart on the third tick, a restart or wake on the fourth. It can also show that a clear or sleep strobe zeroes the count, while strobes that arrive during sleep do not. Coincident events are driven in the same cycle, so that the priority order is tested at the overflow tick itself.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_USB_RST,
    EV_WDT_RST,
    EV_WDT_WAKE,
    EV_IRQ_WAKE,
    EV_SLEEP,
    EV_CLEAR
  } rwc_event_e;
endpackage

// File: rtl/rwc_wdt.sv
module rwc_wdt #(
  parameter int unsigned LIMIT = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic ovf_o
);
  localparam int unsigned CntW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CntW-1:0] Last = CntW'(LIMIT - 1);

  logic [CntW-1:0] cnt_q;

  assign ovf_o = tick_i && (cnt_q == Last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (tick_i)      cnt_q <= (cnt_q == Last) ? '0 : cnt_q + 1'b1;
  end

  initial assert (LIMIT >= 2) else $error("LIMIT must be at least 2");

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} < (CntW+1)'(LIMIT)));
endmodule

// File: rtl/rwc_arbiter.sv
module rwc_arbiter
  import rwc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       usb_rst_i,
  input  logic       wdt_ovf_i,
  input  logic       wdt_clr_i,
  input  logic       sleep_i,
  input  logic       irq_pend_i,
  output rwc_event_e event_o,
  output logic       cnt_clr_o,
  output logic       core_rst_o,
  output logic       wake_o,
  output logic       pc_inc_o,
  output logic       clk_stop_o
);
  logic usb_q;
  logic usb_rise;

  assign usb_rise = usb_rst_i && !usb_q;

  // priority: usb edge > overflow > (asleep: irq | awake: sleep > clear)
  always_comb begin
    event_o = EV_NONE;
    if (usb_rise)            event_o = EV_USB_RST;
    else if (clk_stop_o) begin
      if (wdt_ovf_i)         event_o = EV_WDT_WAKE;
      else if (irq_pend_i)   event_o = EV_IRQ_WAKE;
    end else begin
      if (wdt_ovf_i)         event_o = EV_WDT_RST;
      else if (sleep_i)      event_o = EV_SLEEP;
      else if (wdt_clr_i)    event_o = EV_CLEAR;
    end
  end

  assign cnt_clr_o = (event_o != EV_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usb_q      <= 1'b0;
      core_rst_o <= 1'b1;
      wake_o     <= 1'b0;
      pc_inc_o   <= 1'b0;
      clk_stop_o <= 1'b0;
    end else begin
      usb_q      <= usb_rst_i;
      core_rst_o <= 1'b0;
      wake_o     <= 1'b0;
      unique case (event_o)
        EV_USB_RST, EV_WDT_RST: begin
          core_rst_o <= 1'b1;
          pc_inc_o   <= 1'b0;
          clk_stop_o <= 1'b0;
        end
        EV_WDT_WAKE, EV_IRQ_WAKE: begin
          wake_o     <= 1'b1;
          pc_inc_o   <= 1'b1;
          clk_stop_o <= 1'b0;
        end
        EV_SLEEP: clk_stop_o <= 1'b1;
        default: ;
      endcase
    end
  end

  assert_excl_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(core_rst_o && wake_o));
  assert_wake_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  assert_wake_only_asleep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_stop_o && !usb_rise) |=> !wake_o);
endmodule

// File: rtl/rwc_flags.sv
module rwc_flags
  import rwc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  rwc_event_e event_i,
  output logic       to_flag_o,
  output logic       pd_flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_flag_o <= 1'b1;
      pd_flag_o <= 1'b1;
    end else begin
      unique case (event_i)
        EV_WDT_RST:  begin to_flag_o <= 1'b0; pd_flag_o <= 1'b1; end
        EV_WDT_WAKE: begin to_flag_o <= 1'b0; pd_flag_o <= 1'b0; end
        EV_IRQ_WAKE: begin to_flag_o <= 1'b1; pd_flag_o <= 1'b0; end
        EV_SLEEP:    begin to_flag_o <= 1'b1; pd_flag_o <= 1'b0; end
        EV_CLEAR:    begin to_flag_o <= 1'b1; pd_flag_o <= 1'b1; end
        default: ;   // EV_USB_RST and EV_NONE keep the flags
      endcase
    end
  end
endmodule

// File: rtl/rst_wake_ctrl.sv
module rst_wake_ctrl
  import rwc_pkg::*;
#(
  parameter int unsigned WDT_TICKS = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic usb_rst_i,
  input  logic wdt_clr_i,
  input  logic sleep_i,
  input  logic irq_pend_i,
  output logic core_rst_o,
  output logic wake_o,
  output logic pc_inc_o,
  output logic to_flag_o,
  output logic pd_flag_o,
  output logic clk_stop_o
);
  rwc_event_e ev;
  logic       cnt_clr;
  logic       wdt_ovf;

  rwc_wdt #(.LIMIT(WDT_TICKS)) u_wdt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (cnt_clr),
    .ovf_o  (wdt_ovf)
  );

  rwc_arbiter u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .usb_rst_i  (usb_rst_i),
    .wdt_ovf_i  (wdt_ovf),
    .wdt_clr_i  (wdt_clr_i),
    .sleep_i    (sleep_i),
    .irq_pend_i (irq_pend_i),
    .event_o    (ev),
    .cnt_clr_o  (cnt_clr),
    .core_rst_o (core_rst_o),
    .wake_o     (wake_o),
    .pc_inc_o   (pc_inc_o),
    .clk_stop_o (clk_stop_o)
  );

  rwc_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .event_i   (ev),
    .to_flag_o (to_flag_o),
    .pd_flag_o (pd_flag_o)
  );

  assert_sleep_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_stop_o) |-> (to_flag_o && !pd_flag_o));
  assert_wake_pd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (!pd_flag_o && pc_inc_o && !clk_stop_o));
  assert_usb_keeps_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(usb_rst_i) |=> (core_rst_o && $stable(to_flag_o) && $stable(pd_flag_o)));
  assert_asleep_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_stop_o && !wdt_ovf && !irq_pend_i && !usb_rst_i) |=>
      ($stable(to_flag_o) && $stable(pd_flag_o)));
endmodule

// File: tb/rst_wake_ctrl_tb.sv
module rst_wake_ctrl_tb;
  localparam int unsigned N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, usb = 1'b0, clr = 1'b0, slp = 1'b0, irq = 1'b0;
  logic core_rst, wake, pc_inc, to_f, pd_f, clk_stop;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  rst_wake_ctrl #(.WDT_TICKS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .usb_rst_i(usb),
    .wdt_clr_i(clr), .sleep_i(slp), .irq_pend_i(irq),
    .core_rst_o(core_rst), .wake_o(wake), .pc_inc_o(pc_inc),
    .to_flag_o(to_f), .pd_flag_o(pd_f), .clk_stop_o(clk_stop)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // drive for one edge at a negedge, return at the next negedge
  task automatic cyc(input logic t, input logic c, input logic s, input logic q);
    tick = t; clr = c; slp = s; irq = q;
    @(negedge clk);
    tick = 1'b0; clr = 1'b0; slp = 1'b0; irq = 1'b0;
  endtask

  task automatic chk_state(input string req, input logic r, input logic w,
                           input logic p, input logic t, input logic d, input logic s);
    chk(req, "core_rst", core_rst, r);
    chk(req, "wake", wake, w);
    chk(req, "pc_inc", pc_inc, p);
    chk(req, "to_flag", to_f, t);
    chk(req, "pd_flag", pd_f, d);
    chk(req, "clk_stop", clk_stop, s);
  endtask

  task automatic t_por_R1();
    @(negedge clk); @(negedge clk);
    chk_state("R1", 1, 0, 0, 1, 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "core_rst after release", core_rst, 1'b0);
  endtask

  task automatic t_wdt_reset_R2();
    cyc(0, 1, 0, 0);
    for (int i = 0; i < N - 1; i++) begin
      cyc(1, 0, 0, 0);
      chk("R2", "no early reset", core_rst, 1'b0);
    end
    cyc(1, 0, 0, 0);
    chk_state("R2", 1, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    chk("R2", "pulse width", core_rst, 1'b0);
  endtask

  task automatic t_clear_R3();
    for (int i = 0; i < N - 1; i++) cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    chk("R3", "to after clear", to_f, 1'b1);
    chk("R3", "pd after clear", pd_f, 1'b1);
    for (int i = 0; i < N - 1; i++) begin
      cyc(1, 0, 0, 0);
      chk("R3", "count zeroed", core_rst, 1'b0);
    end
    cyc(1, 0, 0, 0);
    chk("R3", "reset after full period", core_rst, 1'b1);
  endtask

  task automatic t_usb_R7();
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    usb = 1'b1;
    cyc(0, 0, 0, 0);
    chk_state("R7", 1, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    chk("R7", "held level no pulse", core_rst, 1'b0);
    cyc(0, 0, 0, 0);
    chk("R7", "held level no pulse", core_rst, 1'b0);
    usb = 1'b0;
    cyc(0, 0, 0, 0);
    for (int i = 0; i < N - 1; i++) begin
      cyc(1, 0, 0, 0);
      chk("R7", "count zeroed", core_rst, 1'b0);
    end
    cyc(1, 0, 0, 0);
    chk("R7", "reset after full period", core_rst, 1'b1);
  endtask

  task automatic t_sleep_wake_R4_R5();
    cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    chk_state("R4", 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < N - 1; i++) begin
      cyc(1, 0, 0, 0);
      chk("R5", "no early wake", wake, 1'b0);
      chk("R4", "clock stopped", clk_stop, 1'b1);
    end
    cyc(1, 0, 0, 0);
    chk_state("R5", 0, 1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R5", "wake pulse width", wake, 1'b0);
  endtask

  task automatic t_asleep_ignore_R8();
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    chk_state("R8", 0, 0, 1, 1, 0, 1);
    cyc(0, 0, 1, 0);
    chk_state("R8", 0, 0, 1, 1, 0, 1);
    cyc(1, 0, 0, 0);
    chk("R8", "no wake yet", wake, 1'b0);
    cyc(1, 0, 0, 0);
    chk("R8", "count kept, wake", wake, 1'b1);
    chk("R8", "to after wdt wake", to_f, 1'b0);
  endtask

  task automatic t_irq_wake_R6();
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    chk("R6", "still asleep", clk_stop, 1'b1);
    cyc(0, 0, 0, 1);
    chk_state("R6", 0, 1, 1, 1, 0, 0);
  endtask

  task automatic t_irq_awake_R11();
    cyc(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 1);
      chk_state("R11", 0, 0, 1, 1, 1, 0);
    end
  endtask

  task automatic t_usb_asleep_R7();
    cyc(0, 0, 1, 0);
    usb = 1'b1;
    cyc(0, 0, 0, 0);
    chk_state("R7", 1, 0, 0, 1, 0, 0);
    usb = 1'b0;
    cyc(0, 0, 0, 0);
  endtask

  task automatic t_priority_R9();
    cyc(0, 1, 0, 0);
    for (int i = 0; i < N - 1; i++) cyc(1, 0, 0, 0);
    usb = 1'b1;
    cyc(1, 0, 0, 0);
    chk_state("R9", 1, 0, 0, 1, 1, 0);
    usb = 1'b0;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0);
    for (int i = 0; i < N - 1; i++) cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 1);
    chk_state("R9", 0, 1, 1, 0, 0, 0);
  endtask

  initial begin
    t_por_R1();
    t_wdt_reset_R2();
    t_clear_R3();
    t_usb_R7();
    t_sleep_wake_R4_R5();
    t_asleep_ignore_R8();
    t_irq_wake_R6();
    t_irq_awake_R11();
    t_usb_asleep_R7();
    t_priority_R9();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule